// File: doc/BRIEF.md
# Gradient Clock-Synchronization Mode Controller

Each node of a network of locally clocked modules has a tunable oscillator with two speeds. This controller decides, once per local clock cycle, which speed the oscillator should use. Its inputs are phase-offset measurements against each directly connected neighbour. Each measurement has already been sampled and arrives as a thermometer word: one bit per signed threshold, and a bit is set when that neighbour's clock is ahead of the local clock by at least that threshold.

The controller forms the smallest and largest neighbour offset with a bitwise AND and a bitwise OR over the words. It then looks for a threshold level at which some neighbour is far enough ahead while no neighbour is too far behind. If it finds one, the node runs fast. Otherwise it runs slow.

The decision is registered on the local clock. The number of threshold levels per direction (`LEVELS`, default 2) and the number of neighbour ports (`NEIGH`, default 4) are parameters. An unused port is tied to the zero-offset pattern.

Top module: `gcs_mode_ctrl`

## Requirements
- R1: Each neighbour word has 2·LEVELS bits with thresholds in ascending order from bit 0. Bit j < LEVELS has threshold −2·(LEVELS−j) units. Bit j ≥ LEVELS has threshold +2·(j−LEVELS+1) units. Bit j is 1 exactly when the neighbour offset is at least that threshold.
- R2: Every neighbour word is monotone, meaning its set bits form one contiguous run starting at bit 0. The zero-offset word has exactly the lower LEVELS bits set.
- R3: The minimum offset over all neighbours is the bitwise AND of the words. The maximum offset is the bitwise OR. The mode depends only on these two reduced codes.
- R4: The mode is fast exactly when some level s in 1..LEVELS meets both of these conditions:
  - the largest offset is at least +2s units;
  - the smallest offset is at least −2s units.
- R5: When every neighbour offset lies strictly between −2 and +2 units, the mode is slow.
- R6: `fast_o` follows the inputs with exactly one clock cycle of latency.
- R7: A low `rst_n` sampled at a rising clock edge forces `fast_o` to 0 on that edge, whatever the inputs are.
- R8: A neighbour that is behind by more than 2·LEVELS units keeps the mode slow, however far another neighbour is ahead.
- R9: The mode can be fast through a higher level alone. One such case is a largest offset of at least +4 units together with a smallest offset between −4 and −3 units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local node clock |
| rst_n | input | 1 | Synchronous reset, active low |
| offsets_i | input | NEIGH·2·LEVELS | Thermometer words; neighbour k occupies bits [k·2·LEVELS +: 2·LEVELS] |
| fast_o | output | 1 | 1 = fast oscillator mode, 0 = slow |

## Verification
The bench sweeps every combination of neighbour offsets from −5 to +5 units on all four ports. This covers every monotone word and every pairing of minimum and maximum, so a design that tests the wrong bit of a half would fail some combination. So would a design that swaps AND and OR, or that checks only the first level.

Directed cases go after the corners directly:
- a far-behind neighbour that must veto a far-ahead one; a design that ignored the minimum code would go fast here;
- a rescue through the second level alone; a design that looked only at level 1 would stay slow;
- the quiet band around zero, where the mode must stay slow;
- the one-cycle latency; a combinational or two-stage output would be caught by sampling just before and after the edge;
- reset applied while a fast pattern is held at the inputs.

// File: rtl/gcs_pkg.sv
// Package: shared mode encoding and threshold helpers for the controller.
// Assumes thresholds are even multiples of the unit offset, ascending by bit.
package gcs_pkg;

    typedef enum logic {
        MODE_SLOW = 1'b0,
        MODE_FAST = 1'b1
    } gcs_mode_e;

    // Signed threshold (in units) of bit j of a word with 'levels' levels per side.
    function automatic int thr_of_bit(input int levels, input int j);
        return (j < levels) ? -2 * (levels - j) : 2 * (j - levels + 1);
    endfunction

endpackage

// File: rtl/gcs_therm_reduce.sv
// Module: gcs_therm_reduce
// Reduces NEIGH thermometer words to their minimum (bitwise AND) and
// maximum (bitwise OR). Assumes each word is monotone, so the reduced
// codes stay monotone and an unresolved boundary bit only reaches itself.
module gcs_therm_reduce #(
    parameter int NEIGH = 4,
    parameter int WIDTH = 4
) (
    input  logic [NEIGH*WIDTH-1:0] codes_i,
    output logic [WIDTH-1:0]       min_o,
    output logic [WIDTH-1:0]       max_o
);

    logic [WIDTH-1:0] and_chain [NEIGH+1];
    logic [WIDTH-1:0] or_chain  [NEIGH+1];

    assign and_chain[0] = '1;
    assign or_chain[0]  = '0;

    // One stage per neighbour: fold its word into both running reductions.
    for (genvar g = 0; g < NEIGH; g++) begin : g_fold
        assign and_chain[g+1] = and_chain[g] & codes_i[g*WIDTH +: WIDTH];
        assign or_chain[g+1]  = or_chain[g]  | codes_i[g*WIDTH +: WIDTH];
    end

    assign min_o = and_chain[NEIGH];
    assign max_o = or_chain[NEIGH];

endmodule

// File: rtl/gcs_trigger_eval.sv
// Module: gcs_trigger_eval
// Searches all threshold levels for one where the maximum code reaches the
// level's positive threshold and the minimum code reaches its negative one.
// Assumes the word layout of the package: negative half in the low bits.
module gcs_trigger_eval #(
    parameter int LEVELS = 2
) (
    input  logic [2*LEVELS-1:0] min_i,
    input  logic [2*LEVELS-1:0] max_i,
    output logic                fast_o
);

    logic [LEVELS-1:0] level_hit;

    // Level s: ahead bit at LEVELS+s-1 of max, not-behind bit at LEVELS-s of min.
    for (genvar s = 1; s <= LEVELS; s++) begin : g_level
        assign level_hit[s-1] = max_i[LEVELS+s-1] & min_i[LEVELS-s];
    end

    assign fast_o = |level_hit;

endmodule

// File: rtl/gcs_mode_ctrl.sv
// Module: gcs_mode_ctrl (top)
// Per-node mode controller: reduces neighbour thermometer offsets, evaluates
// the fast trigger over all levels and registers the mode on the local clock.
// Assumes sampled, monotone input words; unused ports carry the zero-offset word.
module gcs_mode_ctrl #(
    parameter int NEIGH  = 4,
    parameter int LEVELS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NEIGH*2*LEVELS-1:0]      offsets_i,
    output logic                           fast_o
);
    import gcs_pkg::*;

    localparam int WIDTH = 2 * LEVELS;

    logic [WIDTH-1:0] min_code;
    logic [WIDTH-1:0] max_code;
    logic             fast_d;
    gcs_mode_e        mode_q;

    gcs_therm_reduce #(.NEIGH(NEIGH), .WIDTH(WIDTH)) u_reduce (
        .codes_i (offsets_i),
        .min_o   (min_code),
        .max_o   (max_code)
    );

    gcs_trigger_eval #(.LEVELS(LEVELS)) u_trigger (
        .min_i  (min_code),
        .max_i  (max_code),
        .fast_o (fast_d)
    );

    // Mode register: slow on reset, otherwise the trigger result of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_SLOW;
        else        mode_q <= fast_d ? MODE_FAST : MODE_SLOW;
    end

    assign fast_o = (mode_q == MODE_FAST);

    // Input words must be monotone from bit 0 (R2).
    for (genvar g = 0; g < NEIGH; g++) begin : g_mono_chk
        p_mono_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ((offsets_i[g*WIDTH +: WIDTH] & (offsets_i[g*WIDTH +: WIDTH] + WIDTH'(1))) == '0));
    end

    // Minimum code never has a bit the maximum code lacks (R3).
    p_min_in_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((min_code & ~max_code) == '0));

    // Fast requires, one cycle earlier, someone ahead by the smallest threshold (R4).
    p_fast_needs_ahead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fast_o |-> $past(max_code[LEVELS]));

    // Fast is impossible if, one cycle earlier, someone was beyond the deepest lag (R8).
    p_deep_lag_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !min_code[0] |=> !fast_o);

    // Quiet band around zero keeps the node slow (R5).
    p_quiet_slow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!max_code[LEVELS] && min_code[LEVELS-1]) |=> !fast_o);

endmodule

// File: tb/gcs_mode_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep of integer offsets on four neighbours plus directed
// corner cases; expected mode computed arithmetically from signed offsets.
module gcs_mode_ctrl_bench;

    localparam int NEIGH  = 4;
    localparam int LEVELS = 2;
    localparam int WIDTH  = 2 * LEVELS;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NEIGH*WIDTH-1:0]   offsets = '0;
    logic                     fast;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gcs_mode_ctrl #(.NEIGH(NEIGH), .LEVELS(LEVELS)) u_gcs_mode_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .offsets_i (offsets),
        .fast_o    (fast)
    );

    // R1/R2: thermometer word of a signed offset, thresholds ascending from bit 0.
    function automatic logic [WIDTH-1:0] code_of(input int o);
        logic [WIDTH-1:0] w;
        for (int j = 0; j < WIDTH; j++) begin
            int thr;
            thr  = (j < LEVELS) ? -2 * (LEVELS - j) : 2 * (j - LEVELS + 1);
            w[j] = (o >= thr);
        end
        return w;
    endfunction

    // R4: fast iff some level s has max >= 2s and min >= -2s.
    function automatic logic model(input int a, input int b, input int c, input int d);
        int mx, mn;
        logic f;
        mx = a; mn = a;
        if (b > mx) mx = b;
        if (c > mx) mx = c;
        if (d > mx) mx = d;
        if (b < mn) mn = b;
        if (c < mn) mn = c;
        if (d < mn) mn = d;
        f = 1'b0;
        for (int s = 1; s <= LEVELS; s++)
            if (mx >= 2 * s && mn >= -2 * s) f = 1'b1;
        return f;
    endfunction

    task automatic drive(input int a, input int b, input int c, input int d);
        offsets = {code_of(d), code_of(c), code_of(b), code_of(a)};
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: fast_o=%0b expected %0b", req, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R7: reset with a fast pattern at the inputs keeps the mode slow.
        drive(4, 0, 0, 0);
        repeat (3) @(negedge clk);
        check("R7 reset state", fast, 1'b0);

        // R6: release reset; output rises only after the next rising edge.
        rst_n = 1'b1;
        drive(0, 0, 0, 0);
        @(negedge clk);
        check("R5 all level", fast, 1'b0);
        drive(2, 0, 0, 0);
        #1;
        check("R6 no change before edge", fast, 1'b0);
        @(negedge clk);
        check("R6 one-cycle latency", fast, 1'b1);

        // R7: reset asserted mid-run while the fast pattern is held.
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 reset mid-run", fast, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 resume after reset", fast, 1'b1);

        // R8: deep lag vetoes a far-ahead neighbour.
        drive(5, -5, 0, 0);
        @(negedge clk);
        check("R8 deep lag veto", fast, 1'b0);

        // R9: level 2 alone qualifies.
        drive(4, -3, 0, 0);
        @(negedge clk);
        check("R9 second level rescue", fast, 1'b1);
        drive(3, -3, 0, 0);
        @(negedge clk);
        check("R9 below second threshold", fast, 1'b0);

        // R5: quiet band within one unit either side.
        drive(1, -1, 1, 0);
        @(negedge clk);
        check("R5 quiet band", fast, 1'b0);

        // R3/R4: exhaustive sweep; mode follows only min and max offsets.
        for (int a = -5; a <= 5; a++)
            for (int b = -5; b <= 5; b++)
                for (int c = -5; c <= 5; c++)
                    for (int d = -5; d <= 5; d++) begin
                        drive(a, b, c, d);
                        @(negedge clk);
                        check("R4 sweep", fast, model(a, b, c, d));
                    end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule